// File: doc/BRIEF.md
# Byte Shift, Rotate and Nibble Swap Unit

This unit takes one byte operand, an operation code and the incoming carry, and returns the shifted, rotated or nibble-swapped byte. Alongside the byte it returns the carry, zero, negative, overflow and sign-test flags that the operation produces. A per-flag write-enable mask tells the status logic outside the unit which of those flags to commit. The unit holds no status register and no register file; the surrounding datapath owns both.

Operands enter through a valid/ready handshake. An operand is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output one clock later with `out_valid` high. A result leaves on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the unit sustains one operation per clock. While a result is held by `out_ready` low, `in_ready` is low and the held outputs do not change. `in_valid` may be withdrawn at any time, and input fields are sampled only on an accepting edge.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 (shift left) returns {a[6:0], 0} and carry a[7].
- R2: Code 1 (logical shift right) returns {0, a[7:1]} and carry a[0].
- R3: Code 2 (rotate left through carry) returns {a[6:0], cin} and carry a[7].
- R4: Code 3 (rotate right through carry) returns {cin, a[7:1]} and carry a[0].
- R5: Code 4 (arithmetic shift right) returns {a[7], a[7:1]} and carry a[0].
- R6: Code 5 (nibble swap) returns {a[3:0], a[7:4]}, with the write mask all zero and the flag vector all zero.
- R7: For codes 0 to 4, the flag vector (bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S) has Z = (result == 0), N = result[7], V = N xor C and S = N xor V, and the write mask is 5'b11111.
- R8: Codes 6 and 7 return the operand unchanged, with the write mask and the flag vector all zero.
- R9: An operand accepted on an edge produces `out_valid` high with its result after that same edge, and results leave in acceptance order.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the result, flags and mask stay unchanged.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_op | input | 3 | Operation code (0..7) |
| in_operand | input | 8 | Byte to transform |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Transformed byte |
| out_flags | output | 5 | Flag values {S,V,N,Z,C} |
| out_flag_we | output | 5 | Per-flag write enable, same bit order |

## Verification
A wrong shift path or a mis-routed carry shows on `out_result` or `out_flags[0]` in the first cycle after the offending operand is accepted. The scoreboard compares every result against a model built from the requirements, so the error is reported at that same handshake. A flag derived from the wrong source, such as V computed from the operand instead of the result, shows only for operands where the two differ. The operand patterns therefore include zero, all ones, alternating bits and single set bits at either end. A broken hold register shows as a result that changes while `out_ready` is low, and this is caught on the next stalled cycle.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned FLAG_N = 5;

  typedef enum logic [OP_W-1:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_RLC = 3'd2,
    OP_RRC = 3'd3,
    OP_SRA = 3'd4,
    OP_SWP = 3'd5
  } shrot_op_e;

  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
endpackage

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            cout,
  output logic            upd
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] swapped;

  // Exchange the two halves of the operand.
  generate
    for (genvar i = 0; i < HALF; i++) begin : g_swap
      assign swapped[i]        = a[i + HALF];
      assign swapped[i + HALF] = a[i];
    end
  endgenerate

  always_comb begin
    res  = a;
    cout = 1'b0;
    upd  = 1'b1;
    case (op)
      OP_SHL: begin res = {a[W-2:0], 1'b0};  cout = a[W-1]; end
      OP_SHR: begin res = {1'b0, a[W-1:1]};  cout = a[0];   end
      OP_RLC: begin res = {a[W-2:0], cin};   cout = a[W-1]; end
      OP_RRC: begin res = {cin, a[W-1:1]};   cout = a[0];   end
      OP_SRA: begin res = {a[W-1], a[W-1:1]}; cout = a[0];  end
      OP_SWP: begin res = swapped;           upd  = 1'b0;   end
      default: begin res = a;                upd  = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]      res,
  input  logic              cout,
  input  logic              upd,
  output logic [FLAG_N-1:0] flags,
  output logic [FLAG_N-1:0] we
);
  logic f_z, f_n, f_v;

  assign f_z = ~|res;
  assign f_n = res[W-1];
  assign f_v = f_n ^ cout;

  always_comb begin
    flags = '0;
    we    = '0;
    if (upd) begin
      flags[FLG_C] = cout;
      flags[FLG_Z] = f_z;
      flags[FLG_N] = f_n;
      flags[FLG_V] = f_v;
      flags[FLG_S] = f_n ^ f_v;
      we           = '1;
    end
  end
endmodule

// File: rtl/shrot_stage.sv
module shrot_stage
  import shrot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [W-1:0]      s_res,
  input  logic [FLAG_N-1:0] s_flags,
  input  logic [FLAG_N-1:0] s_we,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [W-1:0]      m_res,
  output logic [FLAG_N-1:0] m_flags,
  output logic [FLAG_N-1:0] m_we
);
  logic load;

  assign s_ready = ~m_valid | m_ready;
  assign load    = s_valid & s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_res   <= '0;
      m_flags <= '0;
      m_we    <= '0;
    end else begin
      if (s_ready) m_valid <= s_valid;
      if (load) begin
        m_res   <= s_res;
        m_flags <= s_flags;
        m_we    <= s_we;
      end
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [W-1:0]      in_operand,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic [FLAG_N-1:0] out_flags,
  output logic [FLAG_N-1:0] out_flag_we
);
  logic [W-1:0]      c_res;
  logic              c_cout;
  logic              c_upd;
  logic [FLAG_N-1:0] c_flags;
  logic [FLAG_N-1:0] c_we;

  shrot_core #(.W(W)) u_core (
    .op   (in_op),
    .a    (in_operand),
    .cin  (in_carry),
    .res  (c_res),
    .cout (c_cout),
    .upd  (c_upd)
  );

  shrot_flags #(.W(W)) u_flags (
    .res   (c_res),
    .cout  (c_cout),
    .upd   (c_upd),
    .flags (c_flags),
    .we    (c_we)
  );

  shrot_stage #(.W(W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_res   (c_res),
    .s_flags (c_flags),
    .s_we    (c_we),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_res   (out_result),
    .m_flags (out_flags),
    .m_we    (out_flag_we)
  );
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_result,
  input logic [FLAG_N-1:0] out_flags,
  input logic [FLAG_N-1:0] out_flag_we
);
  // R11
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_flag_we)));

  // R6
  mask_all_or_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flag_we == '0 || out_flag_we == '1));

  // R8
  masked_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_we == '0) |-> (out_flags == '0));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_we[FLG_Z]) |->
      (out_flags[FLG_Z] == (out_result == '0) && out_flags[FLG_N] == out_result[W-1]));

  // R7
  sign_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_we[FLG_S]) |->
      (out_flags[FLG_V] == (out_flags[FLG_N] ^ out_flags[FLG_C]) &&
       out_flags[FLG_S] == (out_flags[FLG_N] ^ out_flags[FLG_V])));
endmodule

bind shrot_unit shrot_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_flags   (out_flags),
  .out_flag_we (out_flag_we)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_op = '0;
  logic [7:0] in_operand = '0;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [4:0] out_flags;
  logic [4:0] out_flag_we;

  int errors = 0;
  int checks = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] res;
    logic [4:0] flg;
    logic [4:0] we;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  shrot_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_operand(in_operand), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags), .out_flag_we(out_flag_we)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Model written from R1..R8 (flag bits: 0 C, 1 Z, 2 N, 3 V, 4 S).
  function automatic exp_t model(input logic [2:0] op, input logic [7:0] a, input logic c);
    exp_t e;
    logic cy, n, v;
    e.op = op;
    e.flg = '0;
    e.we = '0;
    cy = 1'b0;
    case (op)
      3'd0: begin e.res = a << 1;                       cy = a[7]; end
      3'd1: begin e.res = a >> 1;                       cy = a[0]; end
      3'd2: begin e.res = (a << 1) | {7'd0, c};         cy = a[7]; end
      3'd3: begin e.res = (a >> 1) | {c, 7'd0};         cy = a[0]; end
      3'd4: begin e.res = (a >> 1) | {a[7], 7'd0};      cy = a[0]; end
      3'd5: e.res = {a[3:0], a[7:4]};
      default: e.res = a;
    endcase
    if (op <= 3'd4) begin
      n = e.res[7];
      v = n ^ cy;
      e.flg = {n ^ v, v, n, (e.res == 8'd0), cy};
      e.we = 5'b11111;
    end
    return e;
  endfunction

  task automatic send(input logic [2:0] op, input logic [7:0] a, input logic c);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op;
    in_operand = a;
    in_carry = c;
    acc = 1'b0;
    while (!acc) begin
      #5;
      if (in_ready) begin
        sb.push_back(model(op, a, c));
        acc = 1'b1;
      end
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    #1;
    in_valid = 1'b0;
  endtask

  // Consumer side back-pressure.
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard.
  initial begin
    bit         held = 1'b0;
    logic [7:0] h_res;
    logic [4:0] h_flg, h_we;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (held && out_valid) begin
          checks++;
          if (out_result !== h_res || out_flags !== h_flg || out_flag_we !== h_we) begin
            errors++;
            $display("FAIL R10 held output changed: got %h/%b/%b exp %h/%b/%b",
                     out_result, out_flags, out_flag_we, h_res, h_flg, h_we);
          end
        end
        held = 1'b0;
        if (out_valid && !out_ready) begin
          checks++;
          if (in_ready !== 1'b0) begin
            errors++;
            $display("FAIL R10 in_ready during stall: got %b exp 0", in_ready);
          end
          held = 1'b1;
          h_res = out_result;
          h_flg = out_flags;
          h_we = out_flag_we;
        end
        if (out_valid && out_ready) begin
          checks++;
          if (sb.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected result: got %h exp none", out_result);
          end else begin
            exp_t e;
            e = sb.pop_front();
            if (out_result !== e.res || out_flags !== e.flg || out_flag_we !== e.we) begin
              errors++;
              $display("FAIL %s/R7 op %0d: got res=%h flg=%b we=%b exp res=%h flg=%b we=%b",
                       req_of(e.op), e.op, out_result, out_flags, out_flag_we,
                       e.res, e.flg, e.we);
            end
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got hang exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [8];
    pats = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'h55, 8'hAA, 8'h7F, 8'hA5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    #5;
    // R11 reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: got valid=%b ready=%b exp valid=0 ready=1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    // Directed sweep: every code (R1..R8), both carries, boundary patterns.
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 8; p++)
          send(3'(op), pats[p], 1'(c));

    // R9 ordering and R10 stalls under random back-pressure.
    bp_on = 1'b1;
    for (int i = 0; i < 300; i++)
      send(3'($urandom % 8), 8'($urandom), 1'($urandom % 2));

    repeat (20) @(posedge clk);
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 results missing: got %0d pending exp 0", sb.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule